// File: doc/BRIEF.md
# CMI Receive Decoder

This block turns a unipolar Coded Mark Inversion line into NRZ bits. Each line bit is sent as two half-bit levels. A zero is a low half followed by a high half. A one is a constant level for the whole bit, and its level flips with each successive one. The block has no separate bit clock. It runs on a local clock at eight samples per half-bit and recovers the bit timing from the guaranteed rising edge in the middle of every zero.

Each decoded bit is reported with a one-cycle enable and two flags: one for a malformed half-bit pair, and one for a one that repeats the level of the previous one. The block only reports errors; the data stream is passed on as decoded. Downstream logic uses the enable and the data to run HDB3 or AMI decoding.

The path only runs when the optical receive mode is selected and the code-select field holds the CMI value. In any other setting the block stays silent and drops its bit lock.

Top module: `cmi_rx_decoder`

## Requirements
- R1: Decoding runs only while optical_i is 1 and code_sel_i equals 2'b01. In any other setting bit_en_o, nrz_o, sym_err_o and alt_err_o stay 0 from the next cycle on, and bit lock and the memory of the last one are cleared.
- R2: A half-bit pair (first half, second half) of 01 decodes to nrz_o = 0, and a pair of 00 or 11 decodes to nrz_o = 1.
- R3: The pair 10 is invalid. It is reported with sym_err_o = 1, nrz_o = 0 and alt_err_o = 0. It does not change the memory of the last one's level.
- R4: A one whose level (0 for 00, 1 for 11) equals the level of the previous one since decoding was enabled is reported with alt_err_o = 1 and nrz_o = 1. Zeros and invalid pairs in between do not matter. The first one after enabling is never flagged.
- R5: bit_en_o is a single-cycle pulse, one per decoded bit, every 16 cycles at the nominal rate (OSR = 8). nrz_o, sym_err_o and alt_err_o are 0 whenever bit_en_o is 0.
- R6: After enabling, the first rising line edge is taken as the middle of a bit. The symbol containing that edge is not reported, and output starts with the next symbol.
- R7: Once locked, rising edges within half a half-bit of the expected mid-bit point pull the bit phase back into line. Rising edges at bit boundaries (00 followed by 11) are ignored. Streams whose bits last 15 or 17 samples decode correctly.
- R8: While rst_ni is low, all outputs are 0 and the block is unlocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling clock, 2*OSR cycles per line bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| optical_i | input | 1 | Optical receive mode selected |
| code_sel_i | input | 2 | Receive code select; 2'b01 selects CMI |
| cmi_i | input | 1 | Asynchronous unipolar CMI line |
| nrz_o | output | 1 | Decoded bit, valid with bit_en_o |
| bit_en_o | output | 1 | Recovered bit-clock enable, one pulse per bit |
| sym_err_o | output | 1 | Invalid half-bit pair, valid with bit_en_o |
| alt_err_o | output | 1 | Repeated level of a one, valid with bit_en_o |

## Verification
In one decision cycle, the invalid-pair check and the alternation check are both evaluated on the same pair. An invalid pair that follows a one must raise only the symbol flag. It must also leave the level memory alone, so that the next one is judged against the earlier one. The vector table provokes this with the sequence 11, 10, 00: the bench expects only sym_err_o on the 10 and a clean one on the 00. Separately, the 00-then-11 boundary edge is placed right where a lock would shift the phase. The bench checks that every later bit still arrives exactly 16 cycles after the one before it.

// File: rtl/cmi_rx_pkg.sv
package cmi_rx_pkg;
  localparam logic [1:0] CODE_CMI = 2'b01;

  typedef enum logic [1:0] {
    PAIR_ONE_LO = 2'b00,
    PAIR_ZERO   = 2'b01,
    PAIR_BAD    = 2'b10,
    PAIR_ONE_HI = 2'b11
  } cmi_pair_e;
endpackage

// File: rtl/cmi_rx_sync.sv
module cmi_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  // STAGES synchroniser flops plus one history flop for edge detection
  logic [STAGES:0] sr_q;

  for (genvar g = 0; g <= STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[0] <= 1'b0;
        else         sr_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[g] <= 1'b0;
        else         sr_q[g] <= sr_q[g-1];
      end
    end
  end

  assign lvl_o  = sr_q[STAGES-1];
  assign rise_o = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/cmi_rx_phase.sv
module cmi_rx_phase #(
  parameter int unsigned OSR = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic lvl_i,
  input  logic rise_i,
  output logic decide_o,
  output logic h0_o,
  output logic h1_o
);
  localparam int unsigned BIT_LEN = 2 * OSR;
  localparam int unsigned PW      = $clog2(BIT_LEN);
  localparam logic [PW-1:0] LAST   = PW'(BIT_LEN - 1);
  localparam logic [PW-1:0] MID    = PW'(OSR);
  localparam logic [PW-1:0] S0     = PW'(OSR / 2);
  localparam logic [PW-1:0] S1     = PW'(OSR + OSR / 2);
  localparam logic [PW-1:0] WIN_LO = PW'(OSR / 2);
  localparam logic [PW-1:0] WIN_HI = PW'(OSR + OSR / 2 - 1);

  logic [PW-1:0] ph_q, pos, ph_d;
  logic          locked_q, armed_q, h0_q;
  logic          in_win, accept;

  // ph_q is the position within the bit of the sample now in lvl_i
  assign in_win = (ph_q >= WIN_LO) && (ph_q <= WIN_HI);
  assign accept = en_i && rise_i && (!locked_q || in_win);
  assign pos    = accept ? MID : ph_q;
  assign ph_d   = (pos == LAST) ? '0 : pos + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= '0;
      locked_q <= 1'b0;
      armed_q  <= 1'b0;
      h0_q     <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (pos == S0) h0_q <= lvl_i;
      if (!en_i) begin
        locked_q <= 1'b0;
        armed_q  <= 1'b0;
      end else begin
        if (accept) locked_q <= 1'b1;
        // first-half sample taken under lock: later decisions are trustworthy
        if (pos == S0 && locked_q) armed_q <= 1'b1;
      end
    end
  end

  assign decide_o = en_i && armed_q && (pos == S1);
  assign h0_o     = h0_q;
  assign h1_o     = lvl_i;
endmodule

// File: rtl/cmi_rx_symbol.sv
module cmi_rx_symbol
  import cmi_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic decide_i,
  input  logic h0_i,
  input  logic h1_i,
  output logic bit_en_o,
  output logic nrz_o,
  output logic sym_err_o,
  output logic alt_err_o
);
  cmi_pair_e pair;
  logic      have_one_q, last_lvl_q;
  logic      is_one, nrz_d, sym_d, alt_d;

  assign pair = cmi_pair_e'({h0_i, h1_i});

  always_comb begin
    is_one = 1'b0;
    nrz_d  = 1'b0;
    sym_d  = 1'b0;
    alt_d  = 1'b0;
    unique case (pair)
      PAIR_ZERO: nrz_d = 1'b0;
      PAIR_BAD:  sym_d = 1'b1;
      PAIR_ONE_LO, PAIR_ONE_HI: begin
        is_one = 1'b1;
        nrz_d  = 1'b1;
        alt_d  = have_one_q && (last_lvl_q == h0_i);
      end
      default: nrz_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_en_o   <= 1'b0;
      nrz_o      <= 1'b0;
      sym_err_o  <= 1'b0;
      alt_err_o  <= 1'b0;
      have_one_q <= 1'b0;
      last_lvl_q <= 1'b0;
    end else if (!en_i) begin
      bit_en_o   <= 1'b0;
      nrz_o      <= 1'b0;
      sym_err_o  <= 1'b0;
      alt_err_o  <= 1'b0;
      have_one_q <= 1'b0;
    end else begin
      bit_en_o  <= decide_i;
      nrz_o     <= decide_i & nrz_d;
      sym_err_o <= decide_i & sym_d;
      alt_err_o <= decide_i & alt_d;
      if (decide_i && is_one) begin
        have_one_q <= 1'b1;
        last_lvl_q <= h0_i;
      end
    end
  end
endmodule

// File: rtl/cmi_rx_decoder.sv
module cmi_rx_decoder
  import cmi_rx_pkg::*;
#(
  parameter int unsigned OSR         = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       optical_i,
  input  logic [1:0] code_sel_i,
  input  logic       cmi_i,
  output logic       nrz_o,
  output logic       bit_en_o,
  output logic       sym_err_o,
  output logic       alt_err_o
);
  logic en, lvl, rise, decide, h0, h1;

  assign en = optical_i && (code_sel_i == CODE_CMI);

  cmi_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cmi_i),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  cmi_rx_phase #(.OSR(OSR)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .lvl_i    (lvl),
    .rise_i   (rise),
    .decide_o (decide),
    .h0_o     (h0),
    .h1_o     (h1)
  );

  cmi_rx_symbol u_symbol (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .decide_i  (decide),
    .h0_i      (h0),
    .h1_i      (h1),
    .bit_en_o  (bit_en_o),
    .nrz_o     (nrz_o),
    .sym_err_o (sym_err_o),
    .alt_err_o (alt_err_o)
  );
endmodule

// File: rtl/cmi_rx_decoder_chk.sv
module cmi_rx_decoder_chk
  import cmi_rx_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       optical_i,
  input logic [1:0] code_sel_i,
  input logic       nrz_o,
  input logic       bit_en_o,
  input logic       sym_err_o,
  input logic       alt_err_o
);
  // R1
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(optical_i && code_sel_i == CODE_CMI) |=> !bit_en_o && !nrz_o && !sym_err_o && !alt_err_o);

  // R3
  bad_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_err_o |-> bit_en_o && !nrz_o && !alt_err_o);

  // R4
  alt_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_err_o |-> bit_en_o && nrz_o);

  // R5
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_o |=> !bit_en_o);

  // R5
  gated_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_o |-> !nrz_o && !sym_err_o && !alt_err_o);
endmodule

bind cmi_rx_decoder cmi_rx_decoder_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .optical_i  (optical_i),
  .code_sel_i (code_sel_i),
  .nrz_o      (nrz_o),
  .bit_en_o   (bit_en_o),
  .sym_err_o  (sym_err_o),
  .alt_err_o  (alt_err_o)
);

// File: tb/cmi_rx_decoder_bench.sv
`timescale 1ns/1ps
module cmi_rx_decoder_bench;
  localparam int OSR  = 8;
  localparam int BITC = 2 * OSR;
  localparam int NTBL = 18;
  localparam int NEXP = 128;

  // {h0, h1, exp_nrz, exp_sym, exp_alt}
  localparam logic [4:0] TBL [NTBL] = '{
    5'b01000, 5'b01000, 5'b00100, 5'b01000, 5'b11100, 5'b00100,
    5'b11100, 5'b01000, 5'b10010, 5'b01000, 5'b11101, 5'b00100,
    5'b00101, 5'b01000, 5'b11100, 5'b10010, 5'b00100, 5'b01000
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       optical_i = 1'b0;
  logic [1:0] code_sel_i = 2'b00;
  logic       cmi_i = 1'b0;
  logic       nrz_o, bit_en_o, sym_err_o, alt_err_o;

  int n_chk = 0, n_fail = 0;
  int mon_chk = 0, mon_fail = 0;
  int exp_n = 0, rx_n = 0, seg_start = 0;
  bit chk_period = 1'b0;
  logic  exp_nrz [NEXP];
  logic  exp_sym [NEXP];
  logic  exp_alt [NEXP];
  string exp_tag [NEXP];
  int cyc = 0, last_t = 0;

  always #4 clk = ~clk;

  cmi_rx_decoder #(.OSR(OSR)) u_cmi_rx_decoder (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .optical_i  (optical_i),
    .code_sel_i (code_sel_i),
    .cmi_i      (cmi_i),
    .nrz_o      (nrz_o),
    .bit_en_o   (bit_en_o),
    .sym_err_o  (sym_err_o),
    .alt_err_o  (alt_err_o)
  );

  // monitor: compares every reported bit against the expected list
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (bit_en_o) begin
      if (rx_n < exp_n) begin
        mon_chk <= mon_chk + 1;
        if (nrz_o !== exp_nrz[rx_n] || sym_err_o !== exp_sym[rx_n] || alt_err_o !== exp_alt[rx_n]) begin
          mon_fail <= mon_fail + 1;
          $display("FAIL %s bit %0d act nrz/sym/alt=%b%b%b exp=%b%b%b", exp_tag[rx_n], rx_n,
                   nrz_o, sym_err_o, alt_err_o, exp_nrz[rx_n], exp_sym[rx_n], exp_alt[rx_n]);
        end
      end
      if (chk_period && rx_n > seg_start) begin
        mon_chk <= mon_chk + 1;
        if (cyc - last_t != BITC) begin
          mon_fail <= mon_fail + 1;
          $display("FAIL R5 bit spacing act=%0d exp=%0d", cyc - last_t, BITC);
        end
      end
      last_t <= cyc;
      rx_n   <= rx_n + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  task automatic drive(input logic lvl, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      cmi_i = lvl;
    end
  endtask

  task automatic send_sym(input logic h0, input logic h1, input int l0, input int l1,
                          input bit expect_out, input logic en, input logic es,
                          input logic ea, input string tag);
    if (expect_out) begin
      exp_nrz[exp_n] = en;
      exp_sym[exp_n] = es;
      exp_alt[exp_n] = ea;
      exp_tag[exp_n] = tag;
      exp_n++;
    end
    drive(h0, l0);
    drive(h1, l1);
  endtask

  // enable CMI mode and send the lock symbol, which must not be reported (R6)
  task automatic begin_seg(input bit per);
    seg_start  = exp_n;
    chk_period = per;
    @(negedge clk);
    optical_i  = 1'b1;
    code_sel_i = 2'b01;
    send_sym(1'b0, 1'b1, OSR, OSR, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
  endtask

  task automatic end_seg();
    repeat (2) @(negedge clk);
    optical_i = 1'b0;
    repeat (3) @(negedge clk);
    chk_period = 1'b0;
    chk("R6 reported bit count", rx_n, exp_n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL R5 watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + mon_chk + 1, n_fail + mon_fail + 1);
    $finish;
  end

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk);
    chk("R8 bit_en in reset", bit_en_o, 0);
    chk("R8 nrz in reset", nrz_o, 0);
    chk("R8 flags in reset", {sym_err_o, alt_err_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 bit_en after reset", bit_en_o, 0);

    // table walk at nominal rate: R2 R3 R4 R5 R7
    begin_seg(1'b1);
    for (int i = 0; i < NTBL; i++) begin
      string t;
      t = TBL[i][1] ? "R3" : (TBL[i][0] ? "R4" : "R2");
      send_sym(TBL[i][4], TBL[i][3], OSR, OSR, 1'b1, TBL[i][2], TBL[i][1], TBL[i][0], t);
    end
    end_seg();

    // R1: wrong code select, then optical mode off: nothing reported
    @(negedge clk);
    optical_i  = 1'b1;
    code_sel_i = 2'b10;
    for (int i = 0; i < 6; i++)
      send_sym(TBL[i][4], TBL[i][3], OSR, OSR, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    chk("R1 no output with code_sel 10", rx_n, exp_n);
    optical_i  = 1'b0;
    code_sel_i = 2'b01;
    for (int i = 0; i < 6; i++)
      send_sym(TBL[i][4], TBL[i][3], OSR, OSR, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    chk("R1 no output with optical off", rx_n, exp_n);
    chk("R1 nrz idle when off", nrz_o, 0);

    // R7: slow bits (17 samples); first one after relock is never flagged (R4)
    begin_seg(1'b0);
    send_sym(1'b0, 1'b1, OSR, OSR + 1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    send_sym(1'b0, 1'b0, OSR, OSR + 1, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    send_sym(1'b0, 1'b1, OSR, OSR + 1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    send_sym(1'b1, 1'b1, OSR, OSR + 1, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
    send_sym(1'b0, 1'b0, OSR, OSR + 1, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
    send_sym(1'b0, 1'b1, OSR, OSR + 1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    send_sym(1'b1, 1'b0, OSR, OSR + 1, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
    send_sym(1'b0, 1'b1, OSR, OSR + 1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    end_seg();

    // R7: fast bits (15 samples)
    begin_seg(1'b0);
    send_sym(1'b0, 1'b1, OSR - 1, OSR, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    send_sym(1'b1, 1'b1, OSR - 1, OSR, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
    send_sym(1'b0, 1'b1, OSR - 1, OSR, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    send_sym(1'b1, 1'b1, OSR - 1, OSR, 1'b1, 1'b1, 1'b0, 1'b1, "R7");
    send_sym(1'b0, 1'b0, OSR - 1, OSR, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
    send_sym(1'b0, 1'b1, OSR - 1, OSR, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
    end_seg();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk + mon_chk, n_fail + mon_fail);
    $finish;
  end
endmodule